// File: doc/BRIEF.md
# SPI Burst Master

This block is a register-programmed SPI master. Software uses a small 32-bit register bus to set up a transfer. It chooses the word length, the number of words, the clock mode and the target chip select, then fills a transmit FIFO with the outgoing words. Writing the start bit together with the enable and master bits runs the whole burst on the serial pins without further help from software. Each received word goes into a receive FIFO, and software reads it back after the burst.

The block shifts each word most significant bit first, counting only the programmed number of bits. Received words are right-justified in their 32-bit FIFO entries. A fixed divider parameter sets the serial clock: each half-period of SCLK is `HALF_DIV` system clocks long. A status word reports the following:

- busy while the burst runs;
- a done flag that software clears by writing a 1 to it;
- a sticky error flag that records a transmit FIFO underflow;
- the receive FIFO occupancy.

Software empties either FIFO by writing a 1 to its flush bit in the status word.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the status word at 0x008 reads 0, SCLK is low, MOSI is low and every chip select is at its inactive level. With all polarity bits clear, all four selects are high.
- R2: A write to 0x000 starts a burst only when bits 31 (enable), 28 (master) and 30 (start) are all 1 and no burst is running. Busy (status bit 31) is 1 from the cycle after that write for exactly words x bits x 2 x HALF_DIV cycles. Done (status bit 30) becomes 1 in the cycle busy falls. Writes to 0x000 and 0x004 are ignored while busy, a start without the enable bit does nothing, and bit 30 reads back as 0.
- R3: Bits [4:0] of 0x000 hold the bits per word minus one, so a word is 1 to 32 bits. Each word goes out MSB first from bit (length-1) of its transmit entry.
- R4: Bits [9:5] of 0x000 hold the word count minus one, so a burst carries 1 to 32 words.
- R5: Bit 24 of 0x000 sets the idle SCLK level (0 is low, 1 is high). With bit 21 clear, data is sampled on the first SCLK edge of each bit. With bit 21 set, data changes on the first edge and is sampled on the second.
- R6: Bits [19:18] of 0x004 pick the active select. It is asserted only while busy. The polarity bits for selects 0, 1, 2 and 3 are bits 13, 20, 22 and 23 of 0x000, and a set bit makes that select active-high.
- R7: Bit 30 of 0x004 enables transmit. When it is 0, MOSI sends zeros and the transmit FIFO is not read.
- R8: Bit 31 of 0x004 enables receive. When it is 0, received words are dropped and the receive FIFO occupancy does not change.
- R9: Received words are stored right-justified in the low bits of an entry. Reading 0x180 returns the oldest entry and removes it. Status bits [5:0] give the receive FIFO occupancy.
- R10: If a word is due while transmit is enabled and the transmit FIFO is empty, the word is sent as zeros and status bit 29 is set. Status bit 29 stays set until a 1 is written to it, and writing a 1 to status bit 30 clears done.
- R11: Writing a 1 to status bit 26 empties the transmit FIFO, and writing a 1 to status bit 27 empties the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes an entry when addressing 0x180) |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address and state |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip selects, each with its own polarity |

## Verification
A register write takes effect at the clock edge that ends its write cycle. Busy and the chip select therefore change one cycle after a start, and read data is valid within the same cycle as its address. The bench drives the bus on falling edges and samples 1 ns later, so every check looks at settled outputs halfway between active edges. To catch any off-by-one in the bit counters, the bench counts the cycles from the start write to the first cycle with busy low and requires exactly words x bits x 2 x HALF_DIV. A bench slave captures MOSI on the sampling edge of each clock mode, and FIFO contents are checked only after busy has fallen.

// File: rtl/sbm_pkg.sv
// Shared constants for the SPI burst master: register offsets, bit
// positions that software decodes, and widths derived from the 32-bit bus.
package sbm_pkg;
    localparam int DATA_W   = 32;
    localparam int LEN_W    = $clog2(DATA_W);
    localparam int ADDR_W   = 9;
    localparam int NUM_CS   = 4;
    localparam int CS_SEL_W = $clog2(NUM_CS);

    localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 9'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT = 9'h008;
    localparam logic [ADDR_W-1:0] OFS_TXQ  = 9'h100;
    localparam logic [ADDR_W-1:0] OFS_RXQ  = 9'h180;

    // control word
    localparam int B_CPHA   = 21;
    localparam int B_CPOL   = 24;
    localparam int B_MASTER = 28;
    localparam int B_GO     = 30;
    localparam int B_EN     = 31;
    localparam int CS_POL_BIT [NUM_CS] = '{13, 20, 22, 23};

    // config word
    localparam int B_SEL_LO = 18;
    localparam int B_TXEN   = 30;
    localparam int B_RXEN   = 31;

    // status word
    localparam int B_TXFL   = 26;
    localparam int B_RXFL   = 27;
    localparam int B_ERR    = 29;
    localparam int B_RDY    = 30;
    localparam int B_BSY    = 31;
endpackage

// File: rtl/sbm_fifo.sv
// Synchronous FIFO with flush. Assumes DEPTH is a power of two.
// Push when full and pop when empty are ignored; read data shows the head
// combinationally and reads as zero when empty.
module sbm_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH):0] count,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    // Pointer and occupancy bookkeeping; flush returns to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R9
    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> full); // R9
endmodule

// File: rtl/sbm_engine.sv
// Serial shift engine. Once started it runs (words_m1+1) words of
// (bits_m1+1) bits each. Every bit is two half-periods of HALF_DIV clocks.
// Data changes at the start of a bit and MISO is sampled in the middle.
// The clock mode only inverts the SCLK level in each half.
// Assumes its settings stay stable while busy.
module sbm_engine
    import sbm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  bits_m1,
    input  logic [LEN_W-1:0]  words_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              underflow,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic             half;
    logic [DIV_W-1:0] hcnt;
    logic [LEN_W-1:0] bit_idx, word_idx;
    logic [DATA_W-1:0] tx_word, rx_sh;
    logic half_end, mid_bit, bit_end, word_end, load;

    assign half_end  = busy && (hcnt == DIV_W'(HALF_DIV - 1));
    assign mid_bit   = half_end && !half;
    assign bit_end   = half_end && half;
    assign word_end  = bit_end && (bit_idx == bits_m1);
    assign done      = word_end && (word_idx == words_m1);
    assign load      = start || (word_end && !done);
    assign tx_pop    = load && tx_en && !tx_empty;
    assign underflow = load && tx_en && tx_empty;
    assign rx_push   = word_end && rx_en;
    assign rx_data   = rx_sh;
    assign sclk      = busy ? (cpol ^ cpha ^ half) : cpol;
    assign mosi      = busy && tx_word[bits_m1 - bit_idx];

    // Sequencing: half-period timer, bit and word counters, busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; half <= 1'b0; hcnt <= '0;
            bit_idx <= '0; word_idx <= '0;
        end else if (start) begin
            busy <= 1'b1; half <= 1'b0; hcnt <= '0;
            bit_idx <= '0; word_idx <= '0;
        end else if (busy) begin
            hcnt <= half_end ? '0 : hcnt + 1'b1;
            if (half_end) half <= ~half;
            if (bit_end) begin
                if (word_end) begin
                    bit_idx <= '0;
                    if (done) busy <= 1'b0;
                    else      word_idx <= word_idx + 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    // Data path: load the outgoing word, gather incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            rx_sh   <= '0;
        end else if (load) begin
            tx_word <= (tx_en && !tx_empty) ? tx_data : '0;
            rx_sh   <= '0;
        end else if (mid_bit) begin
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end
    end

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> word_idx <= words_m1); // R4
endmodule

// File: rtl/spi_burst_master.sv
// SPI burst master top: register decode, status flags, chip-select drive,
// and the two FIFOs around the shift engine.
// Assumes a single-cycle register bus with combinational read data.
// A read of the receive window removes the entry on the same cycle.
module spi_burst_master
    import sbm_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int HALF_DIV   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    logic [DATA_W-1:0] ctrl_q, cfg_q, tx_head, rx_word, rx_head, stat_w;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic ready_q, err_q, busy, done, start;
    logic wr_ctrl, wr_cfg, wr_stat;
    logic tx_pop, tx_empty, tx_full, underflow, rx_push, rx_full, rx_empty;
    logic [NUM_CS-1:0] cs_pol;
    logic [CS_SEL_W-1:0] cs_sel;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_cfg  = reg_wr && (reg_addr == OFS_CFG);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign start   = wr_ctrl && !busy && reg_wdata[B_GO] && reg_wdata[B_EN]
                     && reg_wdata[B_MASTER];
    assign cs_sel  = cfg_q[B_SEL_LO +: CS_SEL_W];

    // Configuration words; frozen while a burst runs, start bit not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else if (!busy) begin
            if (wr_ctrl) ctrl_q <= reg_wdata & ~(DATA_W'(1) << B_GO);
            if (wr_cfg)  cfg_q  <= reg_wdata;
        end
    end

    // Done and error flags: hardware set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (done)                            ready_q <= 1'b1;
            else if (wr_stat && reg_wdata[B_RDY]) ready_q <= 1'b0;
            if (underflow)                       err_q <= 1'b1;
            else if (wr_stat && reg_wdata[B_ERR]) err_q <= 1'b0;
        end
    end

    sbm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(wr_stat && reg_wdata[B_TXFL]),
        .push(reg_wr && (reg_addr == OFS_TXQ)), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty));

    sbm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(wr_stat && reg_wdata[B_RXFL]),
        .push(rx_push), .wdata(rx_word),
        .pop(reg_rd && (reg_addr == OFS_RXQ)), .rdata(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty));

    sbm_engine #(.HALF_DIV(HALF_DIV)) engine_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bits_m1(ctrl_q[LEN_W-1:0]), .words_m1(ctrl_q[2*LEN_W-1:LEN_W]),
        .cpol(ctrl_q[B_CPOL]), .cpha(ctrl_q[B_CPHA]),
        .tx_en(cfg_q[B_TXEN]), .rx_en(cfg_q[B_RXEN]),
        .tx_data(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .underflow(underflow), .rx_push(rx_push), .rx_data(rx_word),
        .busy(busy), .done(done), .sclk(spi_sclk), .mosi(spi_mosi),
        .miso(spi_miso));

    // One select line per index, each with its own polarity bit.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_pol[i] = ctrl_q[CS_POL_BIT[i]];
        assign spi_cs[i] = (busy && cs_sel == CS_SEL_W'(i)) ? cs_pol[i] : ~cs_pol[i];
    end

    // Status word assembly.
    always_comb begin
        stat_w             = '0;
        stat_w[B_BSY]      = busy;
        stat_w[B_RDY]      = ready_q;
        stat_w[B_ERR]      = err_q;
        stat_w[CNT_W-1:0]  = rx_count;
    end

    // Read data mux.
    always_comb begin
        case (reg_addr)
            OFS_CTRL: reg_rdata = ctrl_q;
            OFS_CFG:  reg_rdata = cfg_q;
            OFS_STAT: reg_rdata = stat_w;
            OFS_RXQ:  reg_rdata = rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    AST_READY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ready_q); // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(ctrl_q) && $stable(cfg_q)); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R7
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(spi_cs ^ ~cs_pol) <= 1); // R6
endmodule

// File: tb/spi_burst_master_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module spi_burst_master_tb_top;
    import sbm_pkg::*;

    localparam int HD = 2;
    localparam logic [31:0] C_EN = 32'h8000_0000, C_MS = 32'h1000_0000,
                            C_GO = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic spi_sclk, spi_mosi, spi_miso;
    logic [3:0] spi_cs;
    logic loop_mode = 1'b1, miso_level = 1'b0;
    logic cap_cpol = 1'b0, cap_cpha = 1'b0;
    logic [31:0] cap = '0;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    assign spi_miso = loop_mode ? spi_mosi : miso_level;

    spi_burst_master #(.FIFO_DEPTH(32), .HALF_DIV(HD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs(spi_cs));

    // Bench slave: capture MOSI on the sampling edge of the current mode.
    always @(posedge spi_sclk or negedge spi_sclk) begin
        if (spi_sclk == (cap_cpol ^ cap_cpha ^ 1'b1)) cap <= {cap[30:0], spi_mosi};
    end

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Called at the falling edge after the start write; counts busy cycles.
    task automatic wait_done(output int cyc);
        reg_addr = OFS_STAT;
        #1;
        cyc = 0;
        while (reg_rdata[31] && cyc < 20000) begin
            @(negedge clk);
            #1 cyc++;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(int nb, int nw, bit cpol, bit cpha);
        return C_EN | C_MS | C_GO | (32'(cpol) << 24) | (32'(cpha) << 21)
               | (32'(nw - 1) << 5) | 32'(nb - 1);
    endfunction

    function automatic logic [31:0] mask(int nb);
        return (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(OFS_STAT, d);
        chk("R1", "status after reset", d, 32'h0);
        chk("R1", "cs idle", {28'h0, spi_cs}, 32'hF);
        chk("R1", "sclk idle", {31'h0, spi_sclk}, 32'h0);
        chk("R1", "mosi idle", {31'h0, spi_mosi}, 32'h0);
    endtask

    task automatic t_loop(bit cpol, bit cpha, int nb);
        logic [31:0] d;
        logic [31:0] w [3];
        int cyc;
        w[0] = 32'hB4C3_9E71 ^ 32'(nb);
        w[1] = 32'h1F0E_5AD2 ^ 32'(nb);
        w[2] = 32'h8765_43B4 ^ 32'(nb << 3);
        loop_mode = 1'b1; cap_cpol = cpol; cap_cpha = cpha;
        wr(OFS_STAT, 32'h0C00_0000);
        wr(OFS_CFG, 32'hC000_0000);
        for (int i = 0; i < 3; i++) wr(OFS_TXQ, w[i]);
        wr(OFS_CTRL, mk_ctrl(nb, 3, cpol, cpha));
        wait_done(cyc);
        chk("R2", "burst cycles", 32'(cyc), 32'(3 * nb * 2 * HD));
        rd(OFS_STAT, d);
        chk("R4", "rx count after 3 words", {26'h0, d[5:0]}, 32'd3);
        chk("R2", "done flag", {31'h0, d[30]}, 32'h1);
        chk("R5", "sclk back at idle level", {31'h0, spi_sclk}, {31'h0, cpol});
        chk("R3", "msb-first capture of last word", cap & mask(nb), w[2] & mask(nb));
        for (int i = 0; i < 3; i++) begin
            rd(OFS_RXQ, d);
            chk("R5", "loopback word", d, w[i] & mask(nb));
        end
        wr(OFS_STAT, 32'h4000_0000);
        rd(OFS_STAT, d);
        chk("R10", "done cleared by write-one", {31'h0, d[30]}, 32'h0);
    endtask

    task automatic t_cs();
        logic [31:0] d, v;
        int cyc;
        loop_mode = 1'b1;
        wr(OFS_STAT, 32'h0C00_0000);
        wr(OFS_CFG, 32'hC008_0000);
        wr(OFS_TXQ, 32'h0000_1234);
        v = C_EN | C_MS | C_GO | (32'h1 << 13) | (32'h1 << 22) | 32'd15;
        wr(OFS_CTRL, v);
        #1 chk("R6", "select 2 active-high during burst", {28'h0, spi_cs}, 32'hE);
        rd(OFS_STAT, d);
        chk("R2", "busy during burst", {31'h0, d[31]}, 32'h1);
        wr(OFS_CTRL, 32'h9000_FFFF | C_GO);
        wr(OFS_CFG, 32'h0);
        wait_done(cyc);
        rd(OFS_CTRL, d);
        chk("R2", "ctrl unchanged by busy write", d, v & ~C_GO);
        rd(OFS_CFG, d);
        chk("R2", "cfg unchanged by busy write", d, 32'hC008_0000);
        chk("R6", "selects idle after burst", {28'h0, spi_cs}, 32'hA);
        rd(OFS_RXQ, d);
        chk("R6", "word received on select 2", d, 32'h0000_1234);
        wr(OFS_CTRL, C_MS | C_GO | 32'd7);
        rd(OFS_STAT, d);
        chk("R2", "start without enable ignored", {31'h0, d[31]}, 32'h0);
        chk("R6", "polarity bits cleared", {28'h0, spi_cs}, 32'hF);
    endtask

    task automatic t_tx_disable();
        logic [31:0] d;
        int cyc;
        loop_mode = 1'b1;
        wr(OFS_STAT, 32'h2C00_0000);
        wr(OFS_CFG, 32'h8000_0000);
        wr(OFS_TXQ, 32'h0000_00FF);
        wr(OFS_CTRL, mk_ctrl(8, 1, 1'b0, 1'b0));
        wait_done(cyc);
        rd(OFS_RXQ, d);
        chk("R7", "mosi zeros with tx off", d, 32'h0);
        rd(OFS_STAT, d);
        chk("R7", "no underflow with tx off", {31'h0, d[29]}, 32'h0);
        wr(OFS_CFG, 32'hC000_0000);
        wr(OFS_CTRL, mk_ctrl(8, 1, 1'b0, 1'b0));
        wait_done(cyc);
        rd(OFS_RXQ, d);
        chk("R7", "tx word kept while tx off", d, 32'h0000_00FF);
    endtask

    task automatic t_rx_path();
        logic [31:0] d;
        int cyc;
        loop_mode = 1'b0; miso_level = 1'b1;
        wr(OFS_STAT, 32'h0C00_0000);
        wr(OFS_CFG, 32'hC000_0000);
        wr(OFS_TXQ, 32'h0);
        wr(OFS_CTRL, mk_ctrl(5, 1, 1'b0, 1'b1));
        wait_done(cyc);
        rd(OFS_RXQ, d);
        chk("R9", "right-justified 5-bit word", d, 32'h0000_001F);
        rd(OFS_STAT, d);
        chk("R9", "count after read", {26'h0, d[5:0]}, 32'h0);
        wr(OFS_CFG, 32'h4000_0000);
        wr(OFS_TXQ, 32'h0);
        wr(OFS_CTRL, mk_ctrl(5, 1, 1'b0, 1'b1));
        wait_done(cyc);
        rd(OFS_STAT, d);
        chk("R8", "rx off leaves fifo empty", {26'h0, d[5:0]}, 32'h0);
        miso_level = 1'b0;
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        int cyc;
        loop_mode = 1'b1;
        wr(OFS_STAT, 32'h0C00_0000);
        wr(OFS_CFG, 32'hC000_0000);
        wr(OFS_TXQ, 32'h0000_005A);
        wr(OFS_CTRL, mk_ctrl(8, 2, 1'b0, 1'b0));
        wait_done(cyc);
        rd(OFS_STAT, d);
        chk("R10", "underflow error set", {31'h0, d[29]}, 32'h1);
        rd(OFS_RXQ, d);
        chk("R10", "first word intact", d, 32'h0000_005A);
        rd(OFS_RXQ, d);
        chk("R10", "underflow word is zero", d, 32'h0);
        rd(OFS_STAT, d);
        chk("R10", "error sticky", {31'h0, d[29]}, 32'h1);
        wr(OFS_STAT, 32'h2000_0000);
        rd(OFS_STAT, d);
        chk("R10", "error cleared by write-one", {31'h0, d[29]}, 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        int cyc;
        loop_mode = 1'b1;
        wr(OFS_STAT, 32'h0C00_0000);
        wr(OFS_CFG, 32'hC000_0000);
        wr(OFS_TXQ, 32'h0000_0011);
        wr(OFS_STAT, 32'h0400_0000);
        wr(OFS_TXQ, 32'h0000_0022);
        wr(OFS_CTRL, mk_ctrl(8, 1, 1'b0, 1'b0));
        wait_done(cyc);
        rd(OFS_RXQ, d);
        chk("R11", "tx flush dropped old word", d, 32'h0000_0022);
        wr(OFS_TXQ, 32'h0000_0033);
        wr(OFS_CTRL, mk_ctrl(8, 1, 1'b0, 1'b0));
        wait_done(cyc);
        rd(OFS_STAT, d);
        chk("R11", "rx holds one word", {26'h0, d[5:0]}, 32'h1);
        wr(OFS_STAT, 32'h0800_0000);
        rd(OFS_STAT, d);
        chk("R11", "rx flush empties fifo", {26'h0, d[5:0]}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_loop(1'b0, 1'b0, 8);
        t_loop(1'b1, 1'b0, 13);
        t_loop(1'b0, 1'b1, 32);
        t_loop(1'b1, 1'b1, 1);
        t_cs();
        t_tx_disable();
        t_rx_path();
        t_underflow();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule